// File: doc/BRIEF.md
# Banked Status Register Unit

This block keeps the processor status state for a core with several privilege modes. It holds the current status word and a saved status word for each privileged mode. It also holds a stack pointer and a link register for every mode bank. The instruction decoder drives it with one operation per cycle. The operation can be a mode switch, a field-masked status write, a status read or an exception return. The block always presents the current status word, the active saved status word and the active stack pointer and link register.

Each bank is held in storage of its own, and the outputs are taken from the bank chosen by the current mode field. A mode change therefore leaves the outgoing mode's registers in its bank and makes the incoming mode's registers visible. User and System mode share one bank and have no saved status word that software can see. For this bank, writes to the saved word are dropped and reads of it are redirected to the current word. An internal shadow slot lets the active saved output mirror the current word after an exception return into this bank.

Top module: `bsr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the current and every saved status word become 0x0000001F (System mode), every stack pointer and link register becomes 0, and `rd_data` becomes 0.
- R2: A status write builds its mask byte by byte. `wr_fields[3]` enables bits 31:24, `[2]` enables 23:16, `[1]` enables 15:8 and `[0]` enables 7:0. The value comes from `wr_imm_val` when `wr_use_imm` is 1 and from `wr_reg_val` otherwise. The target becomes (old AND NOT mask) OR (value AND mask).
- R3: A status write with `wr_to_saved`=1 in a mode with a bank (FIQ 0x11, IRQ 0x12, Supervisor 0x13, Abort 0x17, Undefined 0x1B) merges into that mode's saved word, and `sav_stat` shows the result on the next cycle.
- R4: A status write with `wr_to_saved`=1 in User (0x10) or System (0x1F) mode changes neither `cur_stat` nor `sav_stat`.
- R5: A read request loads `rd_data` at the next edge. It loads the active saved word when `rd_saved`=1 in a banked mode and the current word in every other case. It sees the state from before that edge.
- R6: A mode switch to a different mode copies the old current word into the incoming mode's saved word and writes the new mode into bits 4:0. The outgoing mode's stack pointer, link register and saved word are kept for later.
- R7: A mode switch to the mode already active changes no output.
- R8: A write to the current word that enables bits 7:0 and alters bits 4:0 performs the R6 mode change, and the merged word becomes the current word.
- R9: An exception return loads the active saved word into the current word. Afterwards `sav_stat` shows the new mode's saved word, or equals the new current word if that mode is User or System.
- R10: When several requests arrive together, exception return wins, then mode switch, then status write. Stack pointer and link register writes from `gpr_wdata` are dropped in a cycle that changes the mode.
- R11: Stack pointer and link register writes go into the bank of the current mode and appear on `act_sp` and `act_lr` on the next cycle. Modes with bit patterns not listed above use the User/System bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 1 | Mode switch request |
| sw_mode | input | 5 | Target mode for a switch |
| wr_req | input | 1 | Status write request |
| wr_to_saved | input | 1 | Status write targets the saved word (1) or the current word (0) |
| wr_use_imm | input | 1 | Select the immediate value (1) or the register value (0) |
| wr_fields | input | 4 | Byte enables for the status write |
| wr_imm_val | input | 32 | Immediate value for a status write |
| wr_reg_val | input | 32 | Register value for a status write |
| rd_req | input | 1 | Status read request |
| rd_saved | input | 1 | Read the saved word (1) or the current word (0) |
| eret | input | 1 | Exception return strobe |
| sp_we | input | 1 | Write the active stack pointer |
| lr_we | input | 1 | Write the active link register |
| gpr_wdata | input | 32 | Data for stack pointer and link register writes |
| cur_stat | output | 32 | Current status word |
| sav_stat | output | 32 | Active saved status word |
| act_sp | output | 32 | Active stack pointer |
| act_lr | output | 32 | Active link register |
| rd_data | output | 32 | Result of the last status read |

## Verification
Directed cases come first. A single-byte write tells the four byte lanes apart, and a switch into IRQ and back shows that the banked stack pointer survives. Writes and reads of the saved word in System mode separate the dropped and redirected paths from the banked ones. Seeded random cycles follow. They mix every request, including simultaneous ones, with targets drawn from all valid modes and some invalid ones. These runs separate the request priority, the shadow mirror after a return into User or System mode, and mode changes made through a low-byte status write from those made by a switch request.

// File: rtl/bsr_pkg.sv
// Package: shared constants and the mode-to-bank mapping for the banked
// status register unit. Assumes 5-bit mode fields in bits 4:0.
package bsr_pkg;
    localparam int XLEN      = 32;
    localparam int MODE_W    = 5;
    localparam int NUM_BANKS = 6;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    // Bank 0 is shared by User, System and any unlisted pattern.
    function automatic logic [BANK_W-1:0] bank_of(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: bank_of = BANK_W'(1);
            MODE_IRQ: bank_of = BANK_W'(2);
            MODE_SVC: bank_of = BANK_W'(3);
            MODE_ABT: bank_of = BANK_W'(4);
            MODE_UND: bank_of = BANK_W'(5);
            default:  bank_of = BANK_W'(0);
        endcase
    endfunction
endpackage

// File: rtl/bsr_field_mask.sv
// Module: expands per-byte field enables into a full-width write mask.
// Assumes the width is a whole number of bytes; enable i covers byte i.
module bsr_field_mask #(
    parameter int W       = 32,
    localparam int NFIELD = W / 8
) (
    input  logic [NFIELD-1:0] fields,
    output logic [W-1:0]      mask
);
    for (genvar i = 0; i < NFIELD; i++) begin : g_byte
        // Replicate one enable across its byte lane.
        assign mask[i*8 +: 8] = {8{fields[i]}};
    end

    // R2: the mask covers exactly eight bits per enabled field.
    always_comb begin
        a_r2_mask_bytes: assert ($countones(mask) == 8 * $countones(fields));
    end
endmodule

// File: rtl/bsr_bank_file.sv
// Module: per-bank storage of the saved status word, stack pointer and
// link register. One saved-word write and one sp/lr write per cycle.
// Assumes the caller gates sp/lr writes; bank 0 holds the shadow slot.
module bsr_bank_file
    import bsr_pkg::*;
#(
    parameter int W  = 32,
    parameter int NB = NUM_BANKS,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] act_bank,
    input  logic          saved_we,
    input  logic [BW-1:0] saved_bank,
    input  logic [W-1:0]  saved_wdata,
    input  logic          sp_we,
    input  logic          lr_we,
    input  logic [W-1:0]  gpr_wdata,
    output logic [W-1:0]  act_saved,
    output logic [W-1:0]  act_sp,
    output logic [W-1:0]  act_lr
);
    logic [W-1:0] saved_q [NB];
    logic [W-1:0] sp_q    [NB];
    logic [W-1:0] lr_q    [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        // Update one bank's three registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                saved_q[b] <= W'(MODE_SYS);
                sp_q[b]    <= '0;
                lr_q[b]    <= '0;
            end else begin
                if (saved_we && saved_bank == BW'(b)) saved_q[b] <= saved_wdata;
                if (sp_we && act_bank == BW'(b))      sp_q[b]    <= gpr_wdata;
                if (lr_we && act_bank == BW'(b))      lr_q[b]    <= gpr_wdata;
            end
        end
    end

    // Present the bank selected by the current mode.
    always_comb begin
        act_saved = saved_q[act_bank];
        act_sp    = sp_q[act_bank];
        act_lr    = lr_q[act_bank];
    end

    // R11: a stack pointer write in a steady bank is visible next cycle.
    a_r11_sp_write: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we ##1 (act_bank == $past(act_bank)) |-> act_sp == $past(gpr_wdata));
endmodule

// File: rtl/bsr_unit.sv
// Module: banked status register unit. Holds the current status word and
// sequences mode switches, masked status writes, status reads and exception
// returns over the bank file. Assumes at most one status operation per cycle
// takes effect, chosen by fixed priority: return, switch, write.
module bsr_unit
    import bsr_pkg::*;
#(
    parameter int W        = XLEN,
    localparam int NFIELD  = W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic [MODE_W-1:0] sw_mode,
    input  logic              wr_req,
    input  logic              wr_to_saved,
    input  logic              wr_use_imm,
    input  logic [NFIELD-1:0] wr_fields,
    input  logic [W-1:0]      wr_imm_val,
    input  logic [W-1:0]      wr_reg_val,
    input  logic              rd_req,
    input  logic              rd_saved,
    input  logic              eret,
    input  logic              sp_we,
    input  logic              lr_we,
    input  logic [W-1:0]      gpr_wdata,
    output logic [W-1:0]      cur_stat,
    output logic [W-1:0]      sav_stat,
    output logic [W-1:0]      act_sp,
    output logic [W-1:0]      act_lr,
    output logic [W-1:0]      rd_data
);
    logic [W-1:0]      cur_q, cur_nxt, rd_q;
    logic [W-1:0]      wmask, wval, sav_act;
    logic [BANK_W-1:0] cur_bank, s_bank;
    logic              cur_has, s_we, mode_chg;
    logic [W-1:0]      s_data;

    bsr_field_mask #(.W(W)) u_mask (
        .fields (wr_fields),
        .mask   (wmask)
    );

    assign wval     = wr_use_imm ? wr_imm_val : wr_reg_val;
    assign cur_bank = bank_of(cur_q[MODE_W-1:0]);
    assign cur_has  = (cur_bank != '0);

    // Choose the winning operation and form the next state.
    always_comb begin
        cur_nxt = cur_q;
        s_we    = 1'b0;
        s_bank  = cur_bank;
        s_data  = cur_q;
        if (eret) begin
            cur_nxt = sav_act;
            if (bank_of(sav_act[MODE_W-1:0]) == '0) begin
                s_we   = 1'b1;
                s_bank = '0;
                s_data = sav_act;
            end
        end else if (sw_req) begin
            if (sw_mode != cur_q[MODE_W-1:0]) begin
                s_we    = 1'b1;
                s_bank  = bank_of(sw_mode);
                s_data  = cur_q;
                cur_nxt = {cur_q[W-1:MODE_W], sw_mode};
            end
        end else if (wr_req) begin
            if (wr_to_saved) begin
                if (cur_has) begin
                    s_we   = 1'b1;
                    s_data = (sav_act & ~wmask) | (wval & wmask);
                end
            end else begin
                cur_nxt = (cur_q & ~wmask) | (wval & wmask);
                if (cur_nxt[MODE_W-1:0] != cur_q[MODE_W-1:0]) begin
                    s_we   = 1'b1;
                    s_bank = bank_of(cur_nxt[MODE_W-1:0]);
                    s_data = cur_q;
                end
            end
        end
    end

    assign mode_chg = (cur_nxt[MODE_W-1:0] != cur_q[MODE_W-1:0]);

    bsr_bank_file #(.W(W), .NB(NUM_BANKS)) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_bank    (cur_bank),
        .saved_we    (s_we),
        .saved_bank  (s_bank),
        .saved_wdata (s_data),
        .sp_we       (sp_we && !mode_chg),
        .lr_we       (lr_we && !mode_chg),
        .gpr_wdata   (gpr_wdata),
        .act_saved   (sav_act),
        .act_sp      (act_sp),
        .act_lr      (act_lr)
    );

    // Register the current status word.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= W'(MODE_SYS);
        else        cur_q <= cur_nxt;
    end

    // Capture a status read, redirected when no saved word exists.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_req) rd_q <= (rd_saved && cur_has) ? sav_act : cur_q;
    end

    assign cur_stat = cur_q;
    assign sav_stat = sav_act;
    assign rd_data  = rd_q;

    // R9: an exception return loads the prior saved word.
    a_r9_return_load: assert property (@(posedge clk) disable iff (!rst_n)
        eret |=> cur_stat == $past(sav_stat));

    // R7: switching to the active mode leaves the status words alone.
    a_r7_same_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !eret && sw_mode == cur_stat[MODE_W-1:0])
        |=> $stable(cur_stat) && $stable(sav_stat));

    // R6: a real switch saves the old current word into the new bank.
    a_r6_switch_save: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !eret && sw_mode != cur_stat[MODE_W-1:0])
        |=> sav_stat == $past(cur_stat) && cur_stat[MODE_W-1:0] == $past(sw_mode));

    // R4: a saved-word write without a bank has no effect.
    a_r4_drop_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_to_saved && !sw_req && !eret && !cur_has)
        |=> $stable(cur_stat) && $stable(sav_stat));

    // R5: a saved-word read without a bank returns the current word.
    a_r5_read_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_saved && !cur_has) |=> rd_data == $past(cur_stat));
endmodule

// File: tb/bsr_unit_tb.sv
module bsr_unit_tb;
    import bsr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_req, wr_req, wr_to_saved, wr_use_imm, rd_req, rd_saved;
    logic        eret, sp_we, lr_we;
    logic [4:0]  sw_mode;
    logic [3:0]  wr_fields;
    logic [31:0] wr_imm_val, wr_reg_val, gpr_wdata;
    logic [31:0] cur_stat, sav_stat, act_sp, act_lr, rd_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference state built from the requirements.
    logic [31:0] m_cur, m_rd;
    logic [31:0] m_sav [6];
    logic [31:0] m_sp  [6];
    logic [31:0] m_lr  [6];

    always #2.5 clk = ~clk;

    bsr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_mode(sw_mode),
        .wr_req(wr_req), .wr_to_saved(wr_to_saved), .wr_use_imm(wr_use_imm),
        .wr_fields(wr_fields), .wr_imm_val(wr_imm_val), .wr_reg_val(wr_reg_val),
        .rd_req(rd_req), .rd_saved(rd_saved), .eret(eret), .sp_we(sp_we),
        .lr_we(lr_we), .gpr_wdata(gpr_wdata), .cur_stat(cur_stat),
        .sav_stat(sav_stat), .act_sp(act_sp), .act_lr(act_lr), .rd_data(rd_data)
    );

    function automatic int bk(input logic [4:0] m);
        case (m)
            5'h11: return 1;
            5'h12: return 2;
            5'h13: return 3;
            5'h17: return 4;
            5'h1B: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input logic [3:0] f);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (f[i]) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [4:0] pick_mode();
        logic [4:0] t [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h05};
        return t[$urandom % 8];
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        sw_req = 0; wr_req = 0; rd_req = 0; eret = 0; sp_we = 0; lr_we = 0;
        wr_to_saved = 0; wr_use_imm = 0; rd_saved = 0; sw_mode = 5'h1F;
        wr_fields = 0; wr_imm_val = 0; wr_reg_val = 0; gpr_wdata = 0;
    endtask

    task automatic model_reset();
        m_cur = 32'h1F; m_rd = 0;
        for (int b = 0; b < 6; b++) begin
            m_sav[b] = 32'h1F; m_sp[b] = 0; m_lr[b] = 0;
        end
    endtask

    // Advance the reference by one edge from the driven inputs.
    task automatic model_step();
        int cb = bk(m_cur[4:0]);
        logic [31:0] sa = m_sav[cb];
        logic [31:0] nc = m_cur;
        logic [31:0] mk = mask_of(wr_fields);
        logic [31:0] v  = wr_use_imm ? wr_imm_val : wr_reg_val;
        if (rd_req) m_rd = (rd_saved && cb != 0) ? sa : m_cur;
        if (eret) begin
            nc = sa;
            if (bk(sa[4:0]) == 0) m_sav[0] = sa;
        end else if (sw_req) begin
            if (sw_mode != m_cur[4:0]) begin
                m_sav[bk(sw_mode)] = m_cur;
                nc = {m_cur[31:5], sw_mode};
            end
        end else if (wr_req) begin
            if (wr_to_saved) begin
                if (cb != 0) m_sav[cb] = (sa & ~mk) | (v & mk);
            end else begin
                nc = (m_cur & ~mk) | (v & mk);
                if (nc[4:0] != m_cur[4:0]) m_sav[bk(nc[4:0])] = m_cur;
            end
        end
        if (nc[4:0] == m_cur[4:0]) begin
            if (sp_we) m_sp[cb] = gpr_wdata;
            if (lr_we) m_lr[cb] = gpr_wdata;
        end
        m_cur = nc;
    endtask

    task automatic compare(input string tag);
        int cb = bk(m_cur[4:0]);
        chk(tag, "cur_stat", cur_stat, m_cur);
        chk(tag, "sav_stat", sav_stat, m_sav[cb]);
        chk(tag, "act_sp",   act_sp,   m_sp[cb]);
        chk(tag, "act_lr",   act_lr,   m_lr[cb]);
        chk(tag, "rd_data",  rd_data,  m_rd);
    endtask

    // Apply the driven inputs for one edge, then check at the falling edge.
    task automatic cycle(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        idle();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        string tag;
        void'($urandom(32'd1234));
        idle();
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        chk("R1", "cur reset", cur_stat, 32'h0000001F);
        rst_n = 1;

        // R2: top byte only, immediate source.
        wr_req = 1; wr_use_imm = 1; wr_fields = 4'b1000;
        wr_imm_val = 32'hABCD_EF00; wr_reg_val = 32'hFFFF_FFFF;
        cycle("R2");
        chk("R2", "byte lane", cur_stat, 32'hAB00_001F);

        // R4: saved write in System mode is dropped.
        wr_req = 1; wr_to_saved = 1; wr_fields = 4'hF; wr_reg_val = 32'h1234_5613;
        cycle("R4");
        chk("R4", "sav unchanged", sav_stat, 32'h0000_001F);

        // R5: saved read in System mode returns current.
        rd_req = 1; rd_saved = 1;
        cycle("R5");
        chk("R5", "redirect", rd_data, 32'hAB00_001F);

        // R11: set System sp, then R6 switch to IRQ and back.
        sp_we = 1; gpr_wdata = 32'h0000_5000;
        cycle("R11");
        sw_req = 1; sw_mode = 5'h12;
        cycle("R6");
        chk("R6", "saved old cur", sav_stat, 32'hAB00_001F);
        chk("R6", "irq sp empty", act_sp, 32'h0);
        sp_we = 1; gpr_wdata = 32'h0000_6000;
        cycle("R11");
        sw_req = 1; sw_mode = 5'h12;
        cycle("R7");
        // R3: write saved word in IRQ.
        wr_req = 1; wr_to_saved = 1; wr_fields = 4'b0001; wr_reg_val = 32'h0000_0013;
        cycle("R3");
        chk("R3", "saved merged", sav_stat, 32'hAB00_0013);
        // R9: return into Supervisor.
        eret = 1;
        cycle("R9");
        chk("R9", "cur from saved", cur_stat, 32'hAB00_0013);
        // R8: low-byte write moves to System; R10 sp write dropped.
        wr_req = 1; wr_fields = 4'b0001; wr_reg_val = 32'h0000_001F; sp_we = 1; gpr_wdata = 32'hDEAD;
        cycle("R8");
        chk("R10", "system sp kept", act_sp, 32'h0000_5000);
        // R10: return beats switch.
        eret = 1; sw_req = 1; sw_mode = 5'h11;
        cycle("R10");

        for (int n = 0; n < 3000; n++) begin
            int r = $urandom % 16;
            sw_req = (r < 4); eret = (r == 4) || (r == 5 && $urandom % 2 == 1);
            wr_req = (r >= 5 && r < 11); rd_req = ($urandom % 3 == 0);
            rd_saved = $urandom % 2; wr_to_saved = $urandom % 2;
            wr_use_imm = $urandom % 2; wr_fields = 4'($urandom);
            sw_mode = pick_mode();
            wr_imm_val = {27'($urandom), pick_mode()};
            wr_reg_val = {27'($urandom), pick_mode()};
            sp_we = ($urandom % 4 == 0); lr_we = ($urandom % 4 == 0);
            gpr_wdata = $urandom;
            if ((eret ? 1 : 0) + (sw_req ? 1 : 0) + (wr_req ? 1 : 0) > 1) tag = "R10";
            else if (eret) tag = "R9";
            else if (sw_req) tag = "R6";
            else if (wr_req) tag = wr_to_saved ? "R3" : "R8";
            else if (rd_req) tag = "R5";
            else tag = "R11";
            cycle(tag);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule